// File: doc/BRIEF.md
# SDRAM Byte-Mask and Read-Latency Data Pipeline

This block sits between a memory controller's command sequencer and the pad ring of a 32-bit SDRAM interface that has four byte lanes. On the read side, a single column-read strobe starts a fixed-length burst of column beats. Each beat is tracked through a latency pipe, so the data returning on the pads is captured exactly as many cycles later as the programmed CAS latency. Byte lanes whose mask was raised two cycles before the capture come back zeroed and flagged invalid. That two-cycle rule is the same for either latency.

On the write side, mask bits act in the very cycle they are sampled. A masked lane of a write beat is neither driven nor stored. The block also decides when the data bus may be driven, and it never turns the drivers on while read data can still arrive. The latency in force is taken from a setting input, but only while no read is in progress.

Top module: `sdram_dq_timing`

## Requirements
- R1: While reset is low, `rd_valid`, `rd_lane_valid`, `rd_data`, `dqm_out`, `dq_oe` and `dq_out` are all zero.
- R2: A high `rd_cmd` at a rising edge issues BURST_LEN (default 4) column beats on that edge and the following consecutive edges. A new `rd_cmd` during a burst restarts the count from that edge.
- R3: Each column beat issued at edge n captures `dq_in` at edge n+CL, where CL is 2 or 3. `rd_valid` is high for the one cycle after that capture edge and is low otherwise.
- R4: A high `term_cmd` (with `rd_cmd` low) stops beat issue at that edge. For a burst that was running, exactly CL-1 further captures follow the `term_cmd` edge: 2 at CL 3 and 1 at CL 2.
- R5: `mask_in[i]` high at edge n marks lane i of any capture at edge n+2 as invalid. For that capture, `rd_lane_valid[i]` is 0 and bits [8i+7:8i] of `rd_data` are zero, whatever the CL. Unmasked lanes of a capture carry `dq_in` and set their `rd_lane_valid` bit. Lane i is bits [8i+7:8i].
- R6: `dqm_out` equals the `mask_in` value sampled at the most recent edge.
- R7: A write beat accepted at edge n drives `dq_oe[i]`=1 and lane i of `dq_out`=lane i of `wr_data` after that same edge for each unmasked lane. A lane masked at edge n has `dq_oe[i]`=0 and a zero lane on `dq_out`, so the write mask has zero latency.
- R8: `wr_cmd` is ignored, leaving `dq_oe` and `dq_out` zero, at any edge where `rd_cmd` is high, beats of a burst remain, or captures are pending.
- R9: `cl_set` (latency in cycles) is adopted at an edge only when no beats remain and no captures are pending, and only if its value is 2 or 3. The adopted value applies to a read started at that same edge. Any other value, or any value presented while busy, leaves the latency unchanged. After reset the latency is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Column read strobe, starts a burst |
| term_cmd | input | 1 | Precharge or burst stop interrupting a read |
| wr_cmd | input | 1 | Write data beat strobe |
| cl_set | input | CL_W (2) | Requested CAS latency in cycles |
| mask_in | input | LANES (4) | Per-lane byte mask |
| wr_data | input | LANES*LANE_W (32) | Write data |
| dq_in | input | LANES*LANE_W (32) | Data arriving from the pads |
| rd_data | output | LANES*LANE_W (32) | Captured read data, masked lanes zeroed |
| rd_valid | output | 1 | A read beat was captured |
| rd_lane_valid | output | LANES (4) | Per-lane validity of the captured beat |
| dqm_out | output | LANES (4) | Byte mask toward the memory |
| dq_out | output | LANES*LANE_W (32) | Write data toward the pads |
| dq_oe | output | LANES (4) | Per-lane pad output enable |

## Verification
A stuck or misplaced bit in the latency pipe shows up as `rd_valid` one cycle early or late, or as a missing or extra beat. This appears at the first capture of the next burst, at most CL+1 cycles after `rd_cmd`. A mask pipe holding the wrong stage blanks the wrong beat's lanes, and the error is seen two or three cycles after the mask toggles. A wrong busy state shows at the ports in two ways. A latency latched while busy moves the next capture. A write enable during the read window drives `dq_oe` in a cycle where the reference model expects zero.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
   localparam int unsigned RD_MASK_LAT = 2;

   function automatic logic cl_in_range(input int unsigned v,
                                        input int unsigned lo,
                                        input int unsigned hi);
      return (v >= lo) && (v <= hi);
   endfunction
endpackage

// File: rtl/sdq_rd_burst.sv
module sdq_rd_burst #(
   parameter int unsigned BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_cmd,
   input  logic term_cmd,
   output logic beat,
   output logic burst_busy
);
   localparam int unsigned CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BURST_LEN - 1);

   generate
      if (BURST_LEN < 1) begin : g_bad_len
         $error("BURST_LEN must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] left_q;

   assign burst_busy = (left_q != '0);
   assign beat       = rd_cmd | (burst_busy & ~term_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left_q <= '0;
      else if (rd_cmd)     left_q <= RELOAD;
      else if (term_cmd)   left_q <= '0;
      else if (burst_busy) left_q <= left_q - CNT_W'(1);
   end
endmodule

// File: rtl/sdq_lat_pipe.sv
module sdq_lat_pipe #(
   parameter int unsigned CL_MIN = 2,
   parameter int unsigned CL_MAX = 3,
   parameter int unsigned CL_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat,
   input  logic            burst_busy,
   input  logic [CL_W-1:0] cl_set,
   output logic            capture,
   output logic            pipe_busy,
   output logic [CL_W-1:0] cl_eff
);
   generate
      if (CL_MIN < 1 || CL_MAX < CL_MIN || CL_MAX >= (1 << CL_W)) begin : g_bad_cl
         $error("CAS latency range does not fit CL_W");
      end
   endgenerate

   logic [CL_MAX-1:0] stage_q, stage_d;
   logic [CL_W-1:0]   cl_q, cl_next;

   always_comb begin
      cl_next = cl_q;
      if (!burst_busy && !pipe_busy &&
          sdq_pkg::cl_in_range(32'(cl_set), CL_MIN, CL_MAX))
         cl_next = cl_set;
   end

   // a beat enters at the stage that leaves exactly CL edges to capture
   genvar k;
   generate
      for (k = 0; k < CL_MAX; k++) begin : g_stage
         logic ins_here;
         assign ins_here = beat && (32'(cl_next) == (CL_MAX - k));
         if (k == 0) begin : g_head
            assign stage_d[k] = ins_here;
         end else begin : g_body
            assign stage_d[k] = ins_here | stage_q[k-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cl_q    <= CL_W'(CL_MAX);
      end else begin
         stage_q <= stage_d;
         cl_q    <= cl_next;
      end
   end

   assign capture   = stage_q[CL_MAX-1];
   assign pipe_busy = |stage_q;
   assign cl_eff    = cl_q;
endmodule

// File: rtl/sdq_mask_pipe.sv
module sdq_mask_pipe #(
   parameter int unsigned LANES = 4,
   parameter int unsigned DEPTH = sdq_pkg::RD_MASK_LAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] mask_in,
   output logic [LANES-1:0] mask_late
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("mask pipe DEPTH must be at least 1");
      end
   endgenerate

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic [DEPTH-1:0] sr_q;
         if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q <= '0;
               else        sr_q <= mask_in[l];
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q <= '0;
               else        sr_q <= {sr_q[DEPTH-2:0], mask_in[l]};
            end
         end
         assign mask_late[l] = sr_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/sdq_wr_path.sv
module sdq_wr_path #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_ok,
   input  logic [LANES-1:0]        mask_in,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic [LANES-1:0]        dq_oe,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic [LANES-1:0]        dqm_out
);
   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic              oe_q, m_q;
         logic [LANE_W-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               oe_q <= 1'b0;
               d_q  <= '0;
               m_q  <= 1'b0;
            end else begin
               oe_q <= wr_ok & ~mask_in[l];
               d_q  <= (wr_ok & ~mask_in[l]) ? wr_data[l*LANE_W +: LANE_W] : '0;
               m_q  <= mask_in[l];
            end
         end
         assign dq_oe[l]                  = oe_q;
         assign dq_out[l*LANE_W +: LANE_W] = d_q;
         assign dqm_out[l]                = m_q;
      end
   endgenerate
endmodule

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CL_MIN    = 2,
   parameter int unsigned CL_MAX    = 3,
   parameter int unsigned CL_W      = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_cmd,
   input  logic                    term_cmd,
   input  logic                    wr_cmd,
   input  logic [CL_W-1:0]         cl_set,
   input  logic [LANES-1:0]        mask_in,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic                    rd_valid,
   output logic [LANES-1:0]        rd_lane_valid,
   output logic [LANES-1:0]        dqm_out,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic [LANES-1:0]        dq_oe
);
   localparam int unsigned DW = LANES * LANE_W;

   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_bus
         $error("LANES and LANE_W must be positive");
      end
   endgenerate

   logic            beat, burst_busy, capture, pipe_busy, rd_busy, wr_ok;
   logic [CL_W-1:0]  cl_eff;
   logic [LANES-1:0] mask_late;

   sdq_rd_burst #(.BURST_LEN(BURST_LEN)) u_burst (
      .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .term_cmd(term_cmd),
      .beat(beat), .burst_busy(burst_busy));

   sdq_lat_pipe #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .CL_W(CL_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .beat(beat), .burst_busy(burst_busy),
      .cl_set(cl_set), .capture(capture), .pipe_busy(pipe_busy),
      .cl_eff(cl_eff));

   sdq_mask_pipe #(.LANES(LANES), .DEPTH(sdq_pkg::RD_MASK_LAT)) u_mask (
      .clk(clk), .rst_n(rst_n), .mask_in(mask_in), .mask_late(mask_late));

   assign rd_busy = burst_busy | pipe_busy;
   assign wr_ok   = wr_cmd & ~rd_cmd & ~rd_busy;

   sdq_wr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .mask_in(mask_in),
      .wr_data(wr_data), .dq_oe(dq_oe), .dq_out(dq_out), .dqm_out(dqm_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= capture;
   end

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_cap
         logic              lv_q;
         logic [LANE_W-1:0] ld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lv_q <= 1'b0;
               ld_q <= '0;
            end else begin
               lv_q <= capture & ~mask_late[l];
               ld_q <= (capture & ~mask_late[l]) ? dq_in[l*LANE_W +: LANE_W] : '0;
            end
         end
         assign rd_lane_valid[l]           = lv_q;
         assign rd_data[l*LANE_W +: LANE_W] = ld_q;
      end
   endgenerate

   logic [DW-1:0] unused_width_probe;
   assign unused_width_probe = '0;
endmodule

// File: rtl/sdram_dq_timing_chk.sv
module sdram_dq_timing_chk #(
   parameter int unsigned LANES = 4,
   parameter int unsigned CL_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_cmd,
   input logic [LANES-1:0] mask_in,
   input logic [LANES-1:0] dqm_out,
   input logic [LANES-1:0] dq_oe,
   input logic             rd_valid,
   input logic [LANES-1:0] rd_lane_valid,
   input logic             rd_busy,
   input logic [CL_W-1:0]  cl_eff
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R6: mask pin follows the sampled mask one register later
   a_r6_dqm_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dqm_out == $past(mask_in)));

   // R7: a lane masked at the write edge is never driven
   a_r7_masked_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((dq_oe & $past(mask_in)) == '0));

   // R8: no drive right after a read command
   a_r8_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> (dq_oe == '0));

   // R3: lane flags only accompany a captured beat
   a_r3_lanes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lane_valid != '0) |-> rd_valid);

   // R5: a mask seen three samples back blanks the lane flag now
   a_r5_mask_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> ((rd_lane_valid & $past(mask_in, 3)) == '0));

   // R9: latency frozen while a read is in progress
   a_r9_cl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |=> $stable(cl_eff));
endmodule

bind sdram_dq_timing sdram_dq_timing_chk #(.LANES(LANES), .CL_W(CL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .mask_in(mask_in),
   .dqm_out(dqm_out), .dq_oe(dq_oe), .rd_valid(rd_valid),
   .rd_lane_valid(rd_lane_valid), .rd_busy(rd_busy), .cl_eff(cl_eff));

// File: tb/sim_sdram_dq_timing.sv
`timescale 1ns/1ps
module sim_sdram_dq_timing;
   localparam int BL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_cmd = 1'b0, term_cmd = 1'b0, wr_cmd = 1'b0;
   logic [1:0]  cl_set = 2'd3;
   logic [3:0]  mask_in = '0;
   logic [31:0] wr_data = '0, dq_in = '0;
   logic [31:0] rd_data, dq_out;
   logic        rd_valid;
   logic [3:0]  rd_lane_valid, dqm_out, dq_oe;

   always #4 clk = ~clk;

   sdram_dq_timing u0 (
      .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .term_cmd(term_cmd),
      .wr_cmd(wr_cmd), .cl_set(cl_set), .mask_in(mask_in), .wr_data(wr_data),
      .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_lane_valid(rd_lane_valid), .dqm_out(dqm_out), .dq_out(dq_out),
      .dq_oe(dq_oe));

   int n_chk = 0, n_fail = 0;
   bit done = 0, chk_en = 0;

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic logic [31:0] spread(input logic [3:0] m);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{m[i]}};
      return r;
   endfunction

   // behavioural reference model
   int          m_rem, m_cl, m_edge;
   int          m_due[$];
   logic [3:0]  m_hist [8];
   logic        e_v;
   logic [3:0]  e_lv, e_dqm, e_oe;
   logic [31:0] e_rd, e_dq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0; m_cl = 3; m_edge = 0; m_due.delete();
         for (int i = 0; i < 8; i++) m_hist[i] = '0;
         e_v = 0; e_lv = '0; e_dqm = '0; e_oe = '0; e_rd = '0; e_dq = '0;
      end else begin
         bit busy, beat, wok;
         busy = (m_rem > 0) || (m_due.size() > 0);
         if (!busy && (cl_set == 2'd2 || cl_set == 2'd3)) m_cl = int'(cl_set);
         e_v = 0;
         if (m_due.size() > 0 && m_due[0] == m_edge) begin
            e_v = 1;
            void'(m_due.pop_front());
         end
         e_lv = e_v ? ~m_hist[(m_edge + 6) % 8] : 4'b0;
         e_rd = dq_in & spread(e_lv);
         beat = rd_cmd || (m_rem > 0 && !term_cmd);
         if (beat) m_due.push_back(m_edge + m_cl);
         if (rd_cmd) m_rem = BL - 1;
         else if (term_cmd) m_rem = 0;
         else if (m_rem > 0) m_rem--;
         wok  = wr_cmd && !rd_cmd && !busy;
         e_oe = wok ? ~mask_in : 4'b0;
         e_dq = wr_data & spread(e_oe);
         e_dqm = mask_in;
         m_hist[m_edge % 8] = mask_in;
         m_edge++;
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         chk(rd_valid == e_v, "R3 rd_valid", {31'b0, rd_valid}, {31'b0, e_v});
         chk(rd_lane_valid == e_lv, "R5 rd_lane_valid", {28'b0, rd_lane_valid}, {28'b0, e_lv});
         chk(rd_data == e_rd, "R5 rd_data", rd_data, e_rd);
         chk(dqm_out == e_dqm, "R6 dqm_out", {28'b0, dqm_out}, {28'b0, e_dqm});
         chk(dq_oe == e_oe, "R7/R8 dq_oe", {28'b0, dq_oe}, {28'b0, e_oe});
         chk(dq_out == e_dq, "R7 dq_out", dq_out, e_dq);
      end
   end

   // window counters for burst-shape checks
   int idx, vcnt, vfirst, vlast;
   task automatic mark();
      idx = 0; vcnt = 0; vfirst = -1; vlast = -1;
   endtask

   task automatic cyc(input logic r, input logic t, input logic w,
                      input logic [1:0] c, input logic [3:0] m,
                      input logic [31:0] d);
      @(negedge clk);
      if (rd_valid) begin
         vcnt++;
         if (vfirst < 0) vfirst = idx;
         vlast = idx;
      end
      idx++;
      rd_cmd = r; term_cmd = t; wr_cmd = w; cl_set = c; mask_in = m;
      wr_data = d; dq_in = $urandom;
   endtask

   task automatic idle(input int n, input logic [1:0] c);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, c, 4'h0, 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      mark();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_valid == 0 && rd_lane_valid == 0, "R1 read flags in reset", {28'b0, rd_lane_valid}, 0);
      chk(rd_data == 0 && dq_out == 0, "R1 data buses in reset", rd_data | dq_out, 0);
      chk(dq_oe == 0 && dqm_out == 0, "R1 oe and mask in reset", {24'b0, dq_oe, dqm_out}, 0);
      rst_n = 1'b1;
      chk_en = 1;

      // R2 and R3 at CL 3
      idle(2, 2'd3); mark();
      cyc(1, 0, 0, 2'd3, 4'h0, 0); idle(10, 2'd3);
      chk(vcnt == BL, "R2 beats per burst", vcnt, BL);
      chk(vfirst == 4, "R3 CL3 first capture", vfirst, 4);

      // R3 at CL 2
      idle(2, 2'd2); mark();
      cyc(1, 0, 0, 2'd2, 4'h0, 0); idle(10, 2'd2);
      chk(vfirst == 3, "R3 CL2 first capture", vfirst, 3);
      chk(vcnt == BL, "R2 beats per burst CL2", vcnt, BL);

      // R2 restart mid-burst
      mark();
      cyc(1, 0, 0, 2'd2, 4'h0, 0); idle(1, 2'd2);
      cyc(1, 0, 0, 2'd2, 4'h0, 0); idle(10, 2'd2);
      chk(vcnt == 6, "R2 restart extends burst", vcnt, 6);

      // R4 interrupt at CL 3 then CL 2
      idle(2, 2'd3); mark();
      cyc(1, 0, 0, 2'd3, 4'h0, 0); idle(2, 2'd3);
      cyc(0, 1, 0, 2'd3, 4'h0, 0); idle(8, 2'd3);
      chk(vcnt == 3, "R4 CL3 captures with stop", vcnt, 3);
      chk(vlast == 6, "R4 CL3 two after stop", vlast, 6);
      idle(2, 2'd2); mark();
      cyc(1, 0, 0, 2'd2, 4'h0, 0); idle(2, 2'd2);
      cyc(0, 1, 0, 2'd2, 4'h0, 0); idle(8, 2'd2);
      chk(vcnt == 3, "R4 CL2 captures with stop", vcnt, 3);
      chk(vlast == 5, "R4 CL2 one after stop", vlast, 5);

      // R9 latency change while busy is ignored, accepted when idle, illegal ignored
      idle(2, 2'd3); mark();
      cyc(1, 0, 0, 2'd3, 4'h0, 0); idle(10, 2'd2);
      chk(vfirst == 4, "R9 busy change ignored", vfirst, 4);
      mark();
      cyc(1, 0, 0, 2'd2, 4'h0, 0); idle(8, 2'd2);
      chk(vfirst == 3, "R9 idle change adopted", vfirst, 3);
      idle(2, 2'd1); mark();
      cyc(1, 0, 0, 2'd1, 4'h0, 0); idle(8, 2'd1);
      chk(vfirst == 3, "R9 illegal value ignored", vfirst, 3);

      // R5 read mask two edges ahead, R7 and R8 writes
      idle(2, 2'd3);
      cyc(1, 0, 0, 2'd3, 4'h0, 0);
      cyc(0, 0, 1, 2'd3, 4'b0010, 32'hDEADBEEF);
      cyc(0, 0, 0, 2'd3, 4'b1000, 0);
      idle(8, 2'd3);
      cyc(0, 0, 1, 2'd3, 4'b0101, 32'h12345678);
      cyc(0, 0, 1, 2'd3, 4'b0000, 32'hCAFEF00D);
      idle(2, 2'd3);

      // mixed traffic
      for (int i = 0; i < 3000; i++)
         cyc(($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 3) == 0,
             2'($urandom), 4'($urandom), $urandom);
      idle(6, 2'd3);
      summary();
   end
endmodule